// File: doc/BRIEF.md
# I2C Byte-Addressed Storage Target with Page-Buffered Writes

This block is an I2C target that fronts a byte-wide storage array. It brings SCL and SDA into the system clock domain and finds START and STOP conditions on the synchronized lines. It answers a 7-bit device address made of a fixed four-bit prefix and three strap inputs, so up to eight copies can share one bus. A write transfer carries two pointer bytes and then a run of data bytes. The data bytes collect in a page buffer and reach the array only when the bus master ends the transfer with STOP. A read transfer streams bytes from the pointer, and the pointer advances after each byte.

After a committing STOP, the block ignores its own address for a fixed number of system clocks. A master polls the device address to find out when the write has finished. A write-protect input, sampled at STOP, throws the buffered page away instead of writing it. SDA is driven only low, through an output enable. The system clock must run at least 16 times faster than SCL.

`MEM_AW` sets the array depth. A full 32768-byte array uses `MEM_AW = 15`. The default is smaller so that the array stays cheap to elaborate.

Top module: `eeprom_i2c_target`

## Requirements
- R1: While reset is held, and right after it is released, `sda_oe_o` is 0 and the block waits for a START.
- R2: The block ACKs (drives SDA low in the ninth clock) a device byte whose upper seven bits equal binary 1010 followed by `strap_i[2:1:0]`. Bit 0 of that byte is 1 for a read and 0 for a write. Any other device byte is NACKed, and the block stays off the bus until the next START.
- R3: In a write transfer, the two bytes after the device byte are the pointer, high byte first. Only the low `MEM_AW` bits of the 16-bit value are kept. Every pointer byte and data byte is ACKed.
- R4: During a write, data byte k goes to page offset (start offset + k) mod 64. The page-select bits of the pointer never change, so byte 65 and later overwrite earlier bytes of the same page.
- R5: Buffered data reaches the array only at a STOP. A repeated START discards it, and no busy period follows.
- R6: After a STOP that ends a write with at least one data byte, the device address is NACKed for `BUSY_CYC` system clocks. `sda_oe_o` stays 0 for that whole time.
- R7: If `wp_i` is 1 when the STOP is seen, no array byte changes. The pointer and data bytes of that transfer are still ACKed.
- R8: A random read is a write transfer that carries only the pointer, then a repeated START with the read bit. Its first byte is the array byte at that pointer.
- R9: Each byte sent in a read advances the pointer by one. The pointer wraps from 2^`MEM_AW`-1 to 0.
- R10: A master NACK after a read byte ends the read. `sda_oe_o` then stays 0 until the next START.
- R11: `sda_oe_o` changes only while SCL is low.
- R12: The ACK is asserted after the eighth SCL falling edge of a byte and released after the ninth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16 times the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write protect, sampled at STOP |

## Verification
Two functions can meet in the same system clock. The first is the STOP that starts a page commit, the same edge at which write protect is latched. The second is a START that lands while that commit is still running, which must neither clear the page buffer nor win an ACK. The bench provokes both. It sends a device address straight after every committing STOP and expects a NACK. It holds write protect high across a STOP and then reads the page back to confirm the old bytes are intact. A per-clock monitor marks every window where the reference model says the bus must be left alone, and it counts any assertion of `sda_oe_o` inside such a window.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_RACK
  } bus_st_e;
endpackage

// File: rtl/eeprom_i2c_sync.sv
module eeprom_i2c_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] line_in;
  logic [1:0] now_s, prev_s;

  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [SYNC_N:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[SYNC_N-1:0], line_in[g]};
    end
    assign now_s[g]  = pipe_q[SYNC_N-1];
    assign prev_s[g] = pipe_q[SYNC_N];
  end

  // bit 1 = scl, bit 0 = sda
  assign sda_o      = now_s[0];
  assign scl_rise_o = now_s[1] & ~prev_s[1];
  assign scl_fall_o = ~now_s[1] & prev_s[1];
  assign start_o    = now_s[1] & prev_s[1] & prev_s[0] & ~now_s[0];
  assign stop_o     = now_s[1] & prev_s[1] & ~prev_s[0] & now_s[0];
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [PAGE_AW-1:0] widx_i,
  input  logic [7:0]         wdata_i,
  input  logic [PAGE_AW-1:0] ridx_i,
  output logic [7:0]         rdata_o,
  output logic               rvalid_o,
  output logic               any_o
);
  localparam int PAGE = 1 << PAGE_AW;

  logic [7:0]    data_q [PAGE];
  logic [PAGE-1:0] vld_q;

  for (genvar i = 0; i < PAGE; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[i] <= '0;
        vld_q[i]  <= 1'b0;
      end else if (clr_i) begin
        vld_q[i]  <= 1'b0;
      end else if (we_i && widx_i == PAGE_AW'(i)) begin
        data_q[i] <= wdata_i;
        vld_q[i]  <= 1'b1;
      end
    end
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = vld_q[ridx_i];
  assign any_o    = |vld_q;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_i2c_pkg::*;
#(
  parameter int MEM_AW   = 11,
  parameter int PAGE_AW  = 6,
  parameter int BUSY_CYC = 1024,
  parameter int SYNC_N   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int PAGE = 1 << PAGE_AW;
  localparam int HI_W = MEM_AW - 8;
  localparam int BCW  = $clog2(BUSY_CYC);
  localparam int PG_W = MEM_AW - PAGE_AW;

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  eeprom_i2c_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  bus_st_e           st_q, nxt_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, tx_q;
  logic              oe_q, mack_q;
  logic [MEM_AW-1:0] ptr_q;
  logic [HI_W-1:0]   ahi_q;
  logic              busy_q, cwp_q;
  logic [BCW-1:0]    bcnt_q;
  logic [PG_W-1:0]   cpage_q;

  logic              byte_done, dev_match;
  logic              pb_we, pb_clr, pb_rvalid, pb_any;
  logic [7:0]        pb_rdata, rd_data;
  logic [PAGE_AW-1:0] cidx;
  logic              in_commit, commit_done, mem_we;

  assign byte_done = scl_fall && cnt_q == 4'd8;
  assign dev_match = sh_q[7:1] == {DEV_PREFIX, strap_i};

  // commit walks the page buffer once at the head of the busy window
  assign cidx        = bcnt_q[PAGE_AW-1:0];
  assign in_commit   = busy_q && (bcnt_q < BCW'(PAGE));
  assign mem_we      = in_commit && pb_rvalid && !cwp_q;
  assign commit_done = busy_q && bcnt_q == BCW'(BUSY_CYC - 1);
  assign pb_we       = st_q == ST_WDAT && byte_done && !start_ev && !stop_ev;
  assign pb_clr      = (start_ev && !busy_q) || commit_done;

  eeprom_page_buf #(.PAGE_AW(PAGE_AW)) u_pbuf (
    .clk_i, .rst_ni,
    .clr_i(pb_clr), .we_i(pb_we), .widx_i(ptr_q[PAGE_AW-1:0]), .wdata_i(sh_q),
    .ridx_i(cidx), .rdata_o(pb_rdata), .rvalid_o(pb_rvalid), .any_o(pb_any)
  );

  eeprom_array #(.AW(MEM_AW)) u_mem (
    .clk_i,
    .we_i(mem_we), .waddr_i({cpage_q, cidx}), .wdata_i(pb_rdata),
    .raddr_i(ptr_q), .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      bcnt_q  <= '0;
      cpage_q <= '0;
      cwp_q   <= 1'b0;
    end else if (busy_q) begin
      bcnt_q <= bcnt_q + 1'b1;
      if (commit_done) busy_q <= 1'b0;
    end else if (stop_ev && pb_any) begin
      busy_q  <= 1'b1;
      bcnt_q  <= '0;
      cpage_q <= ptr_q[MEM_AW-1:PAGE_AW];
      cwp_q   <= wp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      nxt_q  <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
      ptr_q  <= '0;
      ahi_q  <= '0;
    end else if (start_ev) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_ev) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end
          if (byte_done) begin
            cnt_q <= '0;
            st_q  <= ST_ACK;
            oe_q  <= 1'b1;
            unique case (st_q)
              ST_DEV: begin
                if (dev_match && !busy_q) begin
                  nxt_q <= sh_q[0] ? ST_TX : ST_AHI;
                end else begin
                  oe_q <= 1'b0;
                  st_q <= ST_IDLE;
                end
              end
              ST_AHI: begin
                ahi_q <= sh_q[HI_W-1:0];
                nxt_q <= ST_ALO;
              end
              ST_ALO: begin
                ptr_q <= {ahi_q, sh_q};
                nxt_q <= ST_WDAT;
              end
              default: begin
                ptr_q <= {ptr_q[MEM_AW-1:PAGE_AW], ptr_q[PAGE_AW-1:0] + 1'b1};
                nxt_q <= ST_WDAT;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            st_q  <= nxt_q;
            if (nxt_q == ST_TX) begin
              tx_q  <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr_q <= ptr_q + 1'b1;
            end else begin
              oe_q <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= ST_RACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= ~tx_q[6];
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              tx_q  <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr_q <= ptr_q + 1'b1;
              st_q  <= ST_TX;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic busy_q,
  input logic mem_we,
  input logic stop_ev,
  input logic wp_i
);
  assert_idle_after_reset_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !sda_oe_o);

  assert_oe_moves_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  assert_quiet_while_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !sda_oe_o);

  assert_busy_from_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(stop_ev));

  assert_protect_blocks_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ev && wp_i && !busy_q) |=> !mem_we);
endmodule

bind eeprom_i2c_target eeprom_i2c_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .busy_q(busy_q), .mem_we(mem_we), .stop_ev(stop_ev), .wp_i(wp_i)
);

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb;
  localparam int AW   = 11;
  localparam int MASK = (1 << AW) - 1;
  localparam int BUSY = 1024;
  localparam int HALF = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic       sda_oe;
  wire        sda_bus = m_sda & ~sda_oe;

  eeprom_i2c_target #(.MEM_AW(AW), .BUSY_CYC(BUSY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .wp_i(wp)
  );

  int  checks = 0, fails = 0, quiet_viol = 0;
  bit  quiet = 1'b0, done = 1'b0;
  logic [7:0] ref_mem [int];

  // per-clock monitor: model says bus must be left alone (R6, R10)
  always @(negedge clk) if (rst_n && quiet && sda_oe) quiet_viol++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitc(HALF);
    m_scl = 1'b1; waitc(HALF);
    m_sda = 1'b0; waitc(HALF);
    m_scl = 1'b0; waitc(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitc(HALF);
    m_scl = 1'b1; waitc(HALF);
    m_sda = 1'b1; waitc(HALF);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; waitc(HALF);
      m_scl = 1'b1; waitc(HALF);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; waitc(HALF);
    m_scl = 1'b1; waitc(HALF / 2);
    ack = !sda_bus;
    waitc(HALF / 2);
    m_scl = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] b, input bit mack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(HALF);
      m_scl = 1'b1; waitc(HALF / 2);
      b[i] = sda_bus;
      waitc(HALF / 2);
      m_scl = 1'b0;
    end
    m_sda = !mack; waitc(HALF);
    m_scl = 1'b1; waitc(HALF);
    m_scl = 1'b0;
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic write_seq(input int a, input logic [7:0] d[$], input bit protect);
    bit ack;
    wp = protect;
    bus_start();
    wr_byte(dev(0), ack);     chk(ack, "R2", ack, 1);
    wr_byte(8'(a >> 8), ack); chk(ack, "R3", ack, 1);
    wr_byte(8'(a), ack);      chk(ack, "R12", ack, 1);
    foreach (d[k]) begin
      wr_byte(d[k], ack);
      chk(ack, protect ? "R7" : "R3", ack, 1);
    end
    bus_stop();
    if (!protect)
      foreach (d[k]) ref_mem[((a & MASK) & ~63) | (((a & 63) + k) % 64)] = d[k];
    // poll straight away: commit window must refuse the address
    bus_start();
    wr_byte(dev(0), ack);
    chk(!ack, "R6", ack, 0);
    bus_stop();
    quiet = 1'b1;
    waitc(BUSY + 100);
    quiet = 1'b0;
    wp = 1'b0;
  endtask

  task automatic read_seq(input int a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    wr_byte(dev(0), ack);
    wr_byte(8'(a >> 8), ack);
    wr_byte(8'(a), ack);
    bus_start();
    wr_byte(dev(1), ack); chk(ack, "R8", ack, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(b, k < n - 1);
      chk(b === ref_mem[(a + k) & MASK], req, b, ref_mem[(a + k) & MASK]);
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    logic [7:0] q[$];

    waitc(5);
    chk(sda_oe === 1'b0, "R1", sda_oe, 0);
    rst_n = 1'b1;
    waitc(5);
    chk(sda_oe === 1'b0, "R1", sda_oe, 0);

    // wrong strap and wrong prefix: NACK, then silence until START
    bus_start();
    wr_byte({4'b1010, 3'b011, 1'b0}, ack); chk(!ack, "R2", ack, 0);
    quiet = 1'b1;
    wr_byte(8'h00, ack); chk(!ack, "R2", ack, 0);
    quiet = 1'b0;
    bus_stop();
    bus_start();
    wr_byte({4'b1110, strap, 1'b0}, ack); chk(!ack, "R2", ack, 0);
    bus_stop();

    // pointer high bits above MEM_AW ignored
    q = '{8'h11, 8'h22, 8'h33, 8'h44};
    write_seq(16'hF923, q, 1'b0);
    read_seq(16'h0123, 4, "R8");

    // page wrap: 66 bytes from offset 62
    q.delete();
    for (int k = 0; k < 66; k++) q.push_back(8'(k * 3 + 1));
    write_seq(16'h007E, q, 1'b0);
    read_seq(16'h0040, 64, "R4");

    // protected write leaves old data
    q = '{8'hEE, 8'hEF};
    write_seq(16'h0123, q, 1'b1);
    read_seq(16'h0123, 2, "R7");

    // repeated START discards buffered bytes, no busy follows
    bus_start();
    wr_byte(dev(0), ack); wr_byte(8'h01, ack); wr_byte(8'h23, ack);
    wr_byte(8'h77, ack); wr_byte(8'h78, ack);
    bus_start();
    wr_byte(dev(1), ack); chk(ack, "R8", ack, 1);
    rd_byte(b, 1'b0);
    chk(b === ref_mem[16'h125], "R5", b, ref_mem[16'h125]);
    bus_stop();
    bus_start();
    wr_byte(dev(0), ack); chk(ack, "R5", ack, 1);
    bus_stop();
    read_seq(16'h0123, 2, "R5");

    // sequential read wraps top to zero
    q = '{8'hA1, 8'hA2};
    write_seq(MASK - 1, q, 1'b0);
    q = '{8'hB0};
    write_seq(0, q, 1'b0);
    read_seq(MASK - 1, 3, "R9");

    // master NACK ends the read
    bus_start();
    wr_byte(dev(0), ack); wr_byte(8'h00, ack); wr_byte(8'h00, ack);
    bus_start();
    wr_byte(dev(1), ack);
    rd_byte(b, 1'b0);
    chk(b === ref_mem[0], "R9", b, ref_mem[0]);
    quiet = 1'b1;
    rd_byte(b, 1'b0);
    quiet = 1'b0;
    chk(b === 8'hFF, "R10", b, 8'hFF);
    bus_stop();

    chk(quiet_viol == 0, "R10", quiet_viol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule